// File: doc/BRIEF.md
# Software-Managed Unified Translation Buffer

This block is a translation lookaside buffer that instruction fetches and data accesses share. Software fills it completely. No hardware table walker exists. Each entry holds two 32-bit words, a tag word and a data word, and software reaches each word by entry number through an indexed register port.

Each entry has its own page size, anywhere from 1 KB to 16 MB in steps of a factor of four. The page size decides how many high effective-address bits take part in the match. It also decides how many high physical-address bits come from the entry, while the remaining low bits pass straight through as the page offset.

Software also has three maintenance operations:
- Search the buffer for the entry that maps an address. The result arrives one cycle later.
- Drop every entry that maps a given virtual address.
- Drop all entries at once.

The lookup port is combinational. It returns a hit flag, the physical address, the execute and write permissions, a 4-bit zone selector and four cache-attribute flags.

Top module: `swtlb_top`

## Requirements
- R1: After reset every entry is invalid. Both words of every entry read back as zero, and a lookup of any address misses.
- R2: A write with `sw_sel`=1 stores all 32 bits of the data word, and the word reads back unchanged. A write with `sw_sel`=0 stores the tag word fields: page number in bits 31:10, size code in bits 9:7 and valid flag in bit 6. The tag word reads back with bits 5:0 as zero.
- R3: Size code c (0..7) selects a page of 1 KB·4^c. A valid entry matches an address when the address bits from bit 10+2c upward equal the same bits of the tag word. Tag bits below that boundary have no effect.
- R4: On a hit, physical-address bits from 10+2c upward come from data-word bits 31:10. The bits below that boundary are copied from the effective address.
- R5: On a hit, the execute permission is data bit 9, the write permission is data bit 8, the zone is data bits 7:4, and the attributes are data bits 3:0 (write-through bit 3, inhibited bit 2, coherent bit 1, guarded bit 0). On a miss, all of these outputs and the physical address are zero.
- R6: An entry whose valid flag is 0 never hits, in a lookup or in a search.
- R7: When several valid entries match, the lowest-numbered entry supplies the lookup result and the search index.
- R8: A search request is answered one cycle later. `srch_done` is high, and either `srch_hit`=1 with the lowest matching index, or `srch_hit`=0.
- R9: A single-address invalidate clears the valid flag of every entry that matches the given address, each under its own page size. All other entries keep their state.
- R10: Invalidate-all clears every valid flag at the next clock edge. It, and a single-address invalidate, take precedence over a tag write to the same entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr | input | 1 | Register write strobe |
| sw_idx | input | 6 | Entry number for register access |
| sw_sel | input | 1 | Word select: 0 tag, 1 data |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Register read data for the selected word (combinational) |
| srch_req | input | 1 | Search request |
| srch_va | input | 32 | Address to search for |
| srch_done | output | 1 | Search answer valid (one cycle after request) |
| srch_hit | output | 1 | Search found an entry |
| srch_idx | output | 6 | Index of the found entry |
| inv_one | input | 1 | Invalidate the entries that match inv_va |
| inv_va | input | 32 | Address for the single invalidate |
| inv_all | input | 1 | Invalidate every entry |
| lk_ea | input | 32 | Lookup effective address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address |
| lk_ex | output | 1 | Execute permitted |
| lk_wr | output | 1 | Write permitted |
| lk_zone | output | 4 | Zone selector |
| lk_attr | output | 4 | Cache attributes |

## Verification
The assertions assume the following about the inputs:
- Reset is applied before use.
- The register index always names an existing entry.
- A search request lasts one cycle, with its answer sampled before the next request.

The stimulus holds to these rules. Every input changes on the falling clock edge, and no request is held longer than one cycle.

The sweeps place one entry per size code and probe the bits on both sides of the match boundary. The checks then cover overlapping pages of different sizes, for priority and for the invalidate rules.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned PAGE_LSB = 10;
   localparam int unsigned SIZE_W   = 3;
   localparam int unsigned EPN_W    = WORD_W - PAGE_LSB;

   typedef struct packed {
      logic [EPN_W-1:0]  epn;
      logic [SIZE_W-1:0] size;
      logic              valid;
   } tag_t;

   // mask of the address bits that take part in match and translation
   function automatic logic [WORD_W-1:0] page_mask(input logic [SIZE_W-1:0] code);
      int unsigned sh;
      sh = PAGE_LSB + 2 * int'(code);
      return ~((32'h1 << sh) - 32'h1);
   endfunction
endpackage

// File: rtl/swtlb_store.sv
module swtlb_store
   import swtlb_pkg::*;
#(
   parameter int unsigned N_ENT = 64,
   parameter int unsigned IW    = $clog2(N_ENT)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [IW-1:0]                wr_idx,
   input  logic                         wr_sel,
   input  logic [WORD_W-1:0]            wr_data,
   input  logic                         clr_all,
   input  logic [N_ENT-1:0]             clr_vec,
   output tag_t [N_ENT-1:0]             tags_o,
   output logic [N_ENT-1:0][WORD_W-1:0] data_o,
   output logic [N_ENT-1:0]             valid_o
);
   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      tag_t              tag_q;
      logic [WORD_W-1:0] dat_q;
      logic              hit_idx;

      assign hit_idx = wr_en && (wr_idx == IW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_q <= '0;
            dat_q <= '0;
         end else begin
            if (hit_idx && wr_sel)
               dat_q <= wr_data;
            if (hit_idx && !wr_sel) begin
               tag_q.epn   <= wr_data[WORD_W-1:PAGE_LSB];
               tag_q.size  <= wr_data[PAGE_LSB-1:PAGE_LSB-SIZE_W];
               tag_q.valid <= wr_data[PAGE_LSB-SIZE_W-1];
            end
            if (clr_all || clr_vec[i])
               tag_q.valid <= 1'b0;
         end
      end

      assign tags_o[i]  = tag_q;
      assign data_o[i]  = dat_q;
      assign valid_o[i] = tag_q.valid;
   end

   a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (valid_o == '0));

   a_r9_clear_selected: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_vec) |=> ((valid_o & $past(clr_vec)) == '0));

   a_r2_tag_valid_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && !clr_all && !clr_vec[wr_idx])
      |=> (valid_o[$past(wr_idx)] == $past(wr_data[PAGE_LSB-SIZE_W-1])));
endmodule

// File: rtl/swtlb_match.sv
module swtlb_match
   import swtlb_pkg::*;
#(
   parameter int unsigned N_ENT = 64
) (
   input  tag_t [N_ENT-1:0]  tags,
   input  logic [WORD_W-1:0] va,
   output logic [N_ENT-1:0]  hit
);
   for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
      logic [WORD_W-1:0] msk;
      logic [WORD_W-1:0] diff;
      assign msk    = page_mask(tags[i].size);
      assign diff   = va ^ {tags[i].epn, {PAGE_LSB{1'b0}}};
      assign hit[i] = tags[i].valid && ((diff & msk) == '0);
   end
endmodule

// File: rtl/swtlb_prio.sv
module swtlb_prio #(
   parameter int unsigned N_REQ     = 64,
   parameter bit          LOW_FIRST = 1'b1,
   parameter int unsigned IW        = $clog2(N_REQ)
) (
   input  logic [N_REQ-1:0] req,
   output logic             any,
   output logic [IW-1:0]    idx,
   output logic [N_REQ-1:0] grant
);
   if (LOW_FIRST) begin : g_low
      always_comb begin
         idx = '0;
         for (int k = N_REQ - 1; k >= 0; k--)
            if (req[k]) idx = IW'(k);
      end
   end else begin : g_high
      always_comb begin
         idx = '0;
         for (int k = 0; k < N_REQ; k++)
            if (req[k]) idx = IW'(k);
      end
   end

   assign any = |req;

   always_comb begin
      grant = '0;
      if (any) grant[idx] = 1'b1;
   end

   always_comb begin
      a_r7_grant_onehot: assert ($onehot0(grant));
      a_r7_grant_in_req: assert ((grant & ~req) == '0);
   end
endmodule

// File: rtl/swtlb_top.sv
module swtlb_top
   import swtlb_pkg::*;
#(
   parameter int unsigned N_ENT     = 64,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int unsigned IW       = $clog2(N_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr,
   input  logic [IW-1:0]     sw_idx,
   input  logic              sw_sel,
   input  logic [WORD_W-1:0] sw_wdata,
   output logic [WORD_W-1:0] sw_rdata,
   input  logic              srch_req,
   input  logic [WORD_W-1:0] srch_va,
   output logic              srch_done,
   output logic              srch_hit,
   output logic [IW-1:0]     srch_idx,
   input  logic              inv_one,
   input  logic [WORD_W-1:0] inv_va,
   input  logic              inv_all,
   input  logic [WORD_W-1:0] lk_ea,
   output logic              lk_hit,
   output logic [WORD_W-1:0] lk_pa,
   output logic              lk_ex,
   output logic              lk_wr,
   output logic [3:0]        lk_zone,
   output logic [3:0]        lk_attr
);
   if (N_ENT < 2) begin : g_bad_depth
      $error("swtlb_top: N_ENT must be at least 2");
   end
   if ((1 << IW) != N_ENT) begin : g_bad_pow2
      $error("swtlb_top: N_ENT must be a power of two");
   end

   tag_t [N_ENT-1:0]             tags;
   logic [N_ENT-1:0][WORD_W-1:0] datas;
   logic [N_ENT-1:0]             valid_vec;
   logic [N_ENT-1:0]             lk_hits, sr_hits, iv_hits, clr_vec;
   logic [N_ENT-1:0]             lk_grant, unused_sr_grant;
   logic                         lk_any, sr_any;
   logic [IW-1:0]                lk_sel, sr_sel;

   assign clr_vec = inv_one ? iv_hits : '0;

   swtlb_store #(.N_ENT(N_ENT)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(sw_wr), .wr_idx(sw_idx), .wr_sel(sw_sel), .wr_data(sw_wdata),
      .clr_all(inv_all), .clr_vec(clr_vec),
      .tags_o(tags), .data_o(datas), .valid_o(valid_vec)
   );

   swtlb_match #(.N_ENT(N_ENT)) u_match_lk (.tags(tags), .va(lk_ea),   .hit(lk_hits));
   swtlb_match #(.N_ENT(N_ENT)) u_match_sr (.tags(tags), .va(srch_va), .hit(sr_hits));
   swtlb_match #(.N_ENT(N_ENT)) u_match_iv (.tags(tags), .va(inv_va),  .hit(iv_hits));

   swtlb_prio #(.N_REQ(N_ENT), .LOW_FIRST(LOW_FIRST)) u_prio_lk (
      .req(lk_hits), .any(lk_any), .idx(lk_sel), .grant(lk_grant));
   swtlb_prio #(.N_REQ(N_ENT), .LOW_FIRST(LOW_FIRST)) u_prio_sr (
      .req(sr_hits), .any(sr_any), .idx(sr_sel), .grant(unused_sr_grant));

   // lookup datapath
   logic [WORD_W-1:0] lk_dw, lk_msk;
   assign lk_dw  = datas[lk_sel];
   assign lk_msk = page_mask(tags[lk_sel].size);

   always_comb begin
      lk_hit  = lk_any;
      lk_pa   = '0;
      lk_ex   = 1'b0;
      lk_wr   = 1'b0;
      lk_zone = '0;
      lk_attr = '0;
      if (lk_any) begin
         lk_pa   = (lk_dw & lk_msk) | (lk_ea & ~lk_msk);
         lk_ex   = lk_dw[9];
         lk_wr   = lk_dw[8];
         lk_zone = lk_dw[7:4];
         lk_attr = lk_dw[3:0];
      end
   end

   // search answer register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srch_done <= 1'b0;
         srch_hit  <= 1'b0;
         srch_idx  <= '0;
      end else begin
         srch_done <= srch_req;
         srch_hit  <= srch_req && sr_any;
         srch_idx  <= srch_req ? sr_sel : '0;
      end
   end

   // indexed register read
   tag_t rd_tag;
   assign rd_tag   = tags[sw_idx];
   assign sw_rdata = sw_sel ? datas[sw_idx]
                            : {rd_tag.epn, rd_tag.size, rd_tag.valid, 6'b0};

   a_r8_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
      srch_req |=> srch_done);
   a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_req |=> !srch_done && !srch_hit);
   a_r6_search_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_req && sr_any) |=> $past(valid_vec[sr_sel]));
   a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_pa == '0 && !lk_ex && !lk_wr && lk_zone == '0 && lk_attr == '0));
   a_r6_hit_valid: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> ((lk_grant & ~valid_vec) == '0));
endmodule

// File: tb/swtlb_top_bench.sv
module swtlb_top_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_wr = 1'b0, sw_sel = 1'b0;
   logic [5:0]  sw_idx = '0;
   logic [31:0] sw_wdata = '0, sw_rdata;
   logic        srch_req = 1'b0;
   logic [31:0] srch_va = '0;
   logic        srch_done, srch_hit;
   logic [5:0]  srch_idx;
   logic        inv_one = 1'b0, inv_all = 1'b0;
   logic [31:0] inv_va = '0, lk_ea = '0, lk_pa;
   logic        lk_hit, lk_ex, lk_wr;
   logic [3:0]  lk_zone, lk_attr;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   swtlb_top u_swtlb_top (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_idx(sw_idx), .sw_sel(sw_sel),
      .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .srch_req(srch_req),
      .srch_va(srch_va), .srch_done(srch_done), .srch_hit(srch_hit),
      .srch_idx(srch_idx), .inv_one(inv_one), .inv_va(inv_va), .inv_all(inv_all),
      .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_ex(lk_ex), .lk_wr(lk_wr),
      .lk_zone(lk_zone), .lk_attr(lk_attr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] bmask(input int c);
      return ~((32'h1 << (10 + 2*c)) - 32'h1);
   endfunction

   function automatic logic [31:0] mk_tag(input logic [31:0] va, input int c, input bit v);
      return {va[31:10], 3'(c), v, 6'b0};
   endfunction

   task automatic wr(input int idx, input bit sel, input logic [31:0] d);
      @(negedge clk);
      sw_wr = 1'b1; sw_idx = 6'(idx); sw_sel = sel; sw_wdata = d;
      @(negedge clk);
      sw_wr = 1'b0;
   endtask

   task automatic rd(input int idx, input bit sel, output logic [31:0] v);
      @(negedge clk);
      sw_idx = 6'(idx); sw_sel = sel;
      #1 v = sw_rdata;
   endtask

   task automatic look(input logic [31:0] ea);
      @(negedge clk);
      lk_ea = ea;
      #1;
   endtask

   task automatic search(input logic [31:0] va);
      @(negedge clk);
      srch_req = 1'b1; srch_va = va;
      @(posedge clk);
      #1;
      @(negedge clk);
      srch_req = 1'b0;
   endtask

   task automatic kill_all();
      @(negedge clk); inv_all = 1'b1;
      @(negedge clk); inv_all = 1'b0;
   endtask

   task automatic kill_va(input logic [31:0] va);
      @(negedge clk); inv_one = 1'b1; inv_va = va;
      @(negedge clk); inv_one = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, base, rpn, dw, ea;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 64; i += 9) begin
         rd(i, 1'b0, v); chk("R1 tag zero", v, 32'h0);
         rd(i, 1'b1, v); chk("R1 data zero", v, 32'h0);
      end
      look(32'h0); chk("R1 miss", {31'b0, lk_hit}, 32'h0);

      // R2 readback
      wr(33, 1'b1, 32'hDEAD_BEEF);
      rd(33, 1'b1, v); chk("R2 data word", v, 32'hDEAD_BEEF);
      wr(33, 1'b0, 32'hFFFF_FFFF);
      rd(33, 1'b0, v); chk("R2 tag word", v, 32'hFFFF_FFC0);
      kill_all();

      // R3 R4 R5 sweep over every size code
      base = 32'h5A5A_57C0;
      rpn  = 32'h1234_5800;
      for (int c = 0; c < 8; c++) begin
         int idx;
         idx = 10 + c;
         kill_all();
         dw = {rpn[31:10], c[0], c[1], 4'(c + 3), 4'(15 - c)};
         wr(idx, 1'b1, dw);
         wr(idx, 1'b0, mk_tag(base, c, 1'b1));
         ea = base ^ (32'h1 << (9 + 2*c));
         look(ea);
         chk("R3 hit below boundary", {31'b0, lk_hit}, 32'h1);
         chk("R4 pa", lk_pa, (rpn & bmask(c)) | (ea & ~bmask(c)));
         chk("R5 fields", {22'b0, lk_ex, lk_wr, lk_zone, lk_attr},
             {22'b0, c[0], c[1], 4'(c + 3), 4'(15 - c)});
         look(base ^ 32'h3FF);
         chk("R4 pa low offset", lk_pa, (rpn & bmask(c)) | ((base ^ 32'h3FF) & ~bmask(c)));
         ea = base ^ (32'h1 << (10 + 2*c));
         look(ea);
         chk("R3 miss at boundary", {31'b0, lk_hit}, 32'h0);
         chk("R5 miss zero", {lk_pa[31:2], lk_ex, lk_wr} | {24'b0, lk_zone, lk_attr}, 32'h0);
      end
      kill_all();

      // R6 invalid entry never hits
      wr(7, 1'b1, 32'hAAAA_A7FF);
      wr(7, 1'b0, mk_tag(32'h3000_0000, 0, 1'b0));
      look(32'h3000_0010); chk("R6 lookup invalid", {31'b0, lk_hit}, 32'h0);
      search(32'h3000_0010); chk("R6 search invalid", {30'b0, srch_done, srch_hit}, 32'h2);

      // R7 lowest index wins, R8 search
      wr(20, 1'b1, 32'h0BAD_0000);
      wr(20, 1'b0, mk_tag(32'h8000_0000, 7, 1'b1));
      wr(3, 1'b1, 32'h0C00_0C00);
      wr(3, 1'b0, mk_tag(32'h8012_3400, 0, 1'b1));
      look(32'h8012_3456);
      chk("R7 lowest wins", lk_pa, 32'h0C00_0C56);
      look(32'h8012_7456);
      chk("R7 only large page", lk_pa, 32'h0B12_7456);
      search(32'h8012_3456);
      chk("R8 search hit", {24'b0, srch_done, srch_hit, srch_idx}, {24'b0, 2'b11, 6'd3});
      search(32'h8044_0000);
      chk("R8 search large", {24'b0, srch_done, srch_hit, srch_idx}, {24'b0, 2'b11, 6'd20});
      search(32'h9000_0000);
      chk("R8 search none", {30'b0, srch_done, srch_hit}, 32'h2);
      kill_all();

      // R9 single-address invalidate with mixed sizes
      wr(1, 1'b0, mk_tag(32'h4000_1400, 0, 1'b1));
      wr(2, 1'b0, mk_tag(32'h4000_0000, 7, 1'b1));
      wr(4, 1'b1, 32'h7700_0000);
      wr(4, 1'b0, mk_tag(32'h4000_2000, 0, 1'b1));
      wr(6, 1'b0, mk_tag(32'h7000_0000, 0, 1'b1));
      kill_va(32'h4000_1400);
      rd(1, 1'b0, v); chk("R9 small page cleared", {31'b0, v[6]}, 32'h0);
      rd(2, 1'b0, v); chk("R9 large page cleared", {31'b0, v[6]}, 32'h0);
      rd(4, 1'b0, v); chk("R9 neighbour kept", {31'b0, v[6]}, 32'h1);
      rd(6, 1'b0, v); chk("R9 far entry kept", {31'b0, v[6]}, 32'h1);
      look(32'h4000_2004); chk("R9 neighbour translates", lk_pa, 32'h7700_0004);

      // R10 invalidate-all and precedence over a same-cycle write
      for (int i = 0; i < 64; i += 5) wr(i, 1'b0, mk_tag(32'h6000_0000 + (i << 12), 1, 1'b1));
      kill_all();
      begin
         int live;
         live = 0;
         for (int i = 0; i < 64; i++) begin
            rd(i, 1'b0, v);
            live += int'(v[6]);
         end
         chk("R10 no valid after clear", live, 0);
      end
      @(negedge clk);
      sw_wr = 1'b1; sw_idx = 6'd9; sw_sel = 1'b0; sw_wdata = mk_tag(32'h1000_0000, 0, 1'b1);
      inv_all = 1'b1;
      @(negedge clk);
      sw_wr = 1'b0; inv_all = 1'b0;
      rd(9, 1'b0, v); chk("R10 clear beats write", v, mk_tag(32'h1000_0000, 0, 1'b0));

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule